// File: doc/BRIEF.md
# Audio Control Register Bank

This block holds the eight byte-wide control registers of an analog audio enhancement path and turns them into registered control outputs for that path. Two writers share the bank: a serial-bus slave that writes at run time and a start-up loader that copies a stored configuration. Each write names a register index from 0 to 7 and carries a data byte. The outputs are the bass filter select, the input attenuation, the left and right output attenuation, a combined output mute, a bypass flag, a compressor flag, a spatial-processing flag, a headphone flag, and five effect enables with 4-bit levels.

Each effect level stays in storage when its enable is cleared. While the enable is low the level output reads zero. Setting the enable again brings the stored level back without a rewrite. The output mute is raised for a fixed number of clocks after reset. It is also raised by an explicit mute bit, or when either attenuation code is all ones. When zero-crossing alignment is switched on, a new attenuation code waits for a pulse on `zero_cross`, or for a timeout, before it reaches the outputs. This avoids audible clicks.

Top module: `acrb_regbank`

## Requirements
- R1: Reset loads registers 0..7 with 0x40, 0x00, 0x40, 0x30, 0x30, 0x10, 0x10, 0x10. The outputs then read: bass_sel=2, in_atten=0, atten_l=atten_r=0, bypass=1, zc_en=0, comp_en=1, spatial_on=1, hp_mode=0, fx_on=5'h1F, all levels 0.
- R2: Register 0 drives bass_sel from bits [7:5] and in_atten from bits [4:0]. The outputs follow a write two clocks later.
- R3: Register 1 drives zc_en from bit 7, the mute bit from bit 6 and the left code from bits [5:0]. Register 2 drives bypass from bit 6 and the right code from bits [5:0].
- R4: The effects are indexed 0..4: bass (register 3, enable bit 5), width (register 4, enable bit 4), center (register 5, enable bit 4), focus (register 6, enable bit 4) and detail (register 7, enable bit 4). Each level sits in bits [3:0] of its register. fx_on[i] shows enable i. The level output is 0 while the enable is 0, and the stored level returns when the enable is set again.
- R5: When the loader and the slave write the same index in one cycle, the loader's byte is stored. Writes to different indices in one cycle are both stored.
- R6: out_mute is 1 whenever register 1 bit 6 is set, or the applied left or right code is 63.
- R7: out_mute is 1 from reset for PU_CYCLES clocks, and is released afterwards if no other mute cause is present.
- R8: With zc_en set, a changed attenuation code is held until the clock that samples zero_cross high. The code then appears on the output at that edge.
- R9: With zc_en set and no zero_cross pulse, the held code is applied after 2^ZC_TMO_W clocks.
- R10: With zc_en clear, a written attenuation code reaches atten_l or atten_r two clocks after the write.
- R11: Register 3 bit 4 drives comp_en, register 4 bit 5 drives spatial_on and register 5 bit 5 drives hp_mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slv_we | input | 1 | Slave write strobe |
| slv_addr | input | 3 | Slave register index |
| slv_data | input | 8 | Slave write data |
| ldr_we | input | 1 | Loader write strobe |
| ldr_addr | input | 3 | Loader register index |
| ldr_data | input | 8 | Loader write data |
| zero_cross | input | 1 | Zero-crossing pulse from the audio path |
| bass_sel | output | 3 | Bass filter corner select (0..7 = 40, 60, 100, 150, 200, 250, 300, 400 Hz) |
| in_atten | output | 5 | Input attenuation in 1 dB steps |
| atten_l | output | 6 | Applied left attenuation code |
| atten_r | output | 6 | Applied right attenuation code |
| out_mute | output | 1 | Combined output mute |
| bypass | output | 1 | Route input straight to output |
| zc_en | output | 1 | Zero-crossing alignment enabled |
| comp_en | output | 1 | Bass compressor enable |
| spatial_on | output | 1 | Spatial processing enable |
| hp_mode | output | 1 | Headphone mode |
| fx_on | output | 5 | Effect enables, index as in R4 |
| punch_lvl | output | 4 | Effective bass level |
| width_lvl | output | 4 | Effective width level |
| center_lvl | output | 4 | Effective center level |
| focus_lvl | output | 4 | Effective focus level |
| detail_lvl | output | 4 | Effective detail level |

## Verification
The bench clears an effect enable while its level is non-zero and then sets it again. A design that overwrote storage when disabling would come back with a zero level. It drives both writers at the same index in one cycle, where a reversed priority would store the slave's byte. It also drives both writers at different indices, where a shared write path would drop one of the bytes. Attenuation is checked with alignment on, both before and after a zero-crossing pulse and across the timeout. A gate that ignored zc_en would move early, and one with no timeout would never move. The all-ones code on each side and the end of the power-up window are checked against out_mute.

// File: rtl/acrb_pkg.sv
package acrb_pkg;
  localparam int NREG  = 8;
  localparam int AW    = $clog2(NREG);
  localparam int DW    = 8;
  localparam int NFX   = 5;
  localparam int LVW   = 4;
  localparam int ATW   = 6;
  localparam int IAW   = 5;
  localparam int BSW   = 3;

  // power-on contents of each register
  function automatic logic [DW-1:0] rst_val(input int idx);
    case (idx)
      0: return 8'h40;
      1: return 8'h00;
      2: return 8'h40;
      3: return 8'h30;
      4: return 8'h30;
      default: return 8'h10;
    endcase
  endfunction

  // effect i lives in register i+3
  function automatic int fx_reg(input int i);
    return i + 3;
  endfunction

  // bass enable sits one bit higher than the other effects
  function automatic int fx_en_bit(input int i);
    return (i == 0) ? 5 : 4;
  endfunction
endpackage

// File: rtl/acrb_regfile.sv
module acrb_regfile
  import acrb_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     slv_we,
  input  logic [AW-1:0]            slv_addr,
  input  logic [DW-1:0]            slv_data,
  input  logic                     ldr_we,
  input  logic [AW-1:0]            ldr_addr,
  input  logic [DW-1:0]            ldr_data,
  output logic [NREG-1:0][DW-1:0]  regs_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic ldr_hit, slv_hit;
    assign ldr_hit = ldr_we && (ldr_addr == AW'(i));
    assign slv_hit = slv_we && (slv_addr == AW'(i));
    always_ff @(posedge clk) begin
      if (rst)          regs_o[i] <= rst_val(i);
      else if (ldr_hit) regs_o[i] <= ldr_data;   // loader wins a collision
      else if (slv_hit) regs_o[i] <= slv_data;
    end
  end
endmodule

// File: rtl/acrb_powerup.sv
module acrb_powerup #(
  parameter int CYCLES = 200_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic active_o
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      active_o <= 1'b1;
    end else if (active_o) begin
      cnt <= cnt + 1'b1;
      if (cnt == CW'(CYCLES - 1)) active_o <= 1'b0;
    end
  end
endmodule

// File: rtl/acrb_zc_gate.sv
module acrb_zc_gate #(
  parameter int W     = 6,
  parameter int TMO_W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         align_en,
  input  logic         zc_pulse,
  input  logic [W-1:0] target,
  output logic [W-1:0] applied
);
  logic [TMO_W-1:0] wait_cnt;
  logic             pending, release_now;

  assign pending     = (target != applied);
  assign release_now = !align_en || zc_pulse || (&wait_cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      applied  <= '0;
      wait_cnt <= '0;
    end else if (!pending) begin
      wait_cnt <= '0;
    end else if (release_now) begin
      applied  <= target;
      wait_cnt <= '0;
    end else begin
      wait_cnt <= wait_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/acrb_regbank.sv
module acrb_regbank
  import acrb_pkg::*;
#(
  parameter int PU_CYCLES = 200_000_000,
  parameter int ZC_TMO_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 slv_we,
  input  logic [AW-1:0]        slv_addr,
  input  logic [DW-1:0]        slv_data,
  input  logic                 ldr_we,
  input  logic [AW-1:0]        ldr_addr,
  input  logic [DW-1:0]        ldr_data,
  input  logic                 zero_cross,
  output logic [BSW-1:0]       bass_sel,
  output logic [IAW-1:0]       in_atten,
  output logic [ATW-1:0]       atten_l,
  output logic [ATW-1:0]       atten_r,
  output logic                 out_mute,
  output logic                 bypass,
  output logic                 zc_en,
  output logic                 comp_en,
  output logic                 spatial_on,
  output logic                 hp_mode,
  output logic [NFX-1:0]       fx_on,
  output logic [LVW-1:0]       punch_lvl,
  output logic [LVW-1:0]       width_lvl,
  output logic [LVW-1:0]       center_lvl,
  output logic [LVW-1:0]       focus_lvl,
  output logic [LVW-1:0]       detail_lvl
);
  localparam int RG_MAIN = 0;
  localparam int RG_LEFT = 1;
  localparam int RG_RGHT = 2;

  logic [NREG-1:0][DW-1:0] regs;
  logic                    pu_active;
  logic [1:0][ATW-1:0]     att_app;

  acrb_regfile u_rf (
    .clk      (clk),
    .rst      (rst),
    .slv_we   (slv_we),
    .slv_addr (slv_addr),
    .slv_data (slv_data),
    .ldr_we   (ldr_we),
    .ldr_addr (ldr_addr),
    .ldr_data (ldr_data),
    .regs_o   (regs)
  );

  acrb_powerup #(.CYCLES(PU_CYCLES)) u_pu (
    .clk      (clk),
    .rst      (rst),
    .active_o (pu_active)
  );

  for (genvar s = 0; s < 2; s++) begin : g_side
    acrb_zc_gate #(.W(ATW), .TMO_W(ZC_TMO_W)) u_gate (
      .clk      (clk),
      .rst      (rst),
      .align_en (regs[RG_LEFT][7]),
      .zc_pulse (zero_cross),
      .target   (regs[RG_LEFT + s][ATW-1:0]),
      .applied  (att_app[s])
    );
  end

  assign atten_l = att_app[0];
  assign atten_r = att_app[1];

  logic [NFX-1:0][LVW-1:0] lvl_q;
  for (genvar f = 0; f < NFX; f++) begin : g_fx
    localparam int RI = fx_reg(f);
    localparam int EB = fx_en_bit(f);
    localparam logic [DW-1:0] RV = rst_val(RI);
    always_ff @(posedge clk) begin
      if (rst) begin
        fx_on[f] <= RV[EB];
        lvl_q[f] <= '0;
      end else begin
        fx_on[f] <= regs[RI][EB];
        lvl_q[f] <= regs[RI][EB] ? regs[RI][LVW-1:0] : '0;
      end
    end
  end

  assign punch_lvl  = lvl_q[0];
  assign width_lvl  = lvl_q[1];
  assign center_lvl = lvl_q[2];
  assign focus_lvl  = lvl_q[3];
  assign detail_lvl = lvl_q[4];

  always_ff @(posedge clk) begin
    if (rst) begin
      bass_sel   <= rst_val(RG_MAIN)[7:5];
      in_atten   <= rst_val(RG_MAIN)[IAW-1:0];
      out_mute   <= 1'b1;
      bypass     <= rst_val(RG_RGHT)[6];
      zc_en      <= rst_val(RG_LEFT)[7];
      comp_en    <= rst_val(3)[4];
      spatial_on <= rst_val(4)[5];
      hp_mode    <= rst_val(5)[5];
    end else begin
      bass_sel   <= regs[RG_MAIN][7:5];
      in_atten   <= regs[RG_MAIN][IAW-1:0];
      out_mute   <= pu_active | regs[RG_LEFT][6] | (&att_app[0]) | (&att_app[1]);
      bypass     <= regs[RG_RGHT][6];
      zc_en      <= regs[RG_LEFT][7];
      comp_en    <= regs[3][4];
      spatial_on <= regs[4][5];
      hp_mode    <= regs[5][5];
    end
  end
endmodule

// File: rtl/acrb_regbank_chk.sv
module acrb_regbank_chk #(
  parameter int PU_CYCLES = 200_000_000
) (
  input logic       clk,
  input logic       rst,
  input logic [2:0] bass_sel,
  input logic [5:0] atten_l,
  input logic [5:0] atten_r,
  input logic       out_mute,
  input logic       bypass,
  input logic [4:0] fx_on,
  input logic [3:0] punch_lvl,
  input logic [3:0] width_lvl,
  input logic [3:0] center_lvl,
  input logic [3:0] focus_lvl,
  input logic [3:0] detail_lvl
);
  localparam int CW = $clog2(PU_CYCLES + 1);
  logic [CW-1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != CW'(PU_CYCLES)) since_rst <= since_rst + 1'b1;
  end

  AST_PU_MUTE: assert property (@(posedge clk) disable iff (rst)
    (since_rst < CW'(PU_CYCLES)) |-> out_mute); // R7

  AST_MUTE_LEFT_CODE: assert property (@(posedge clk) disable iff (rst)
    (atten_l == 6'h3F) |=> out_mute); // R6

  AST_MUTE_RIGHT_CODE: assert property (@(posedge clk) disable iff (rst)
    (atten_r == 6'h3F) |=> out_mute); // R6

  AST_LVL_MASK: assert property (@(posedge clk) disable iff (rst)
    ((!fx_on[0] -> punch_lvl == 4'd0) && (!fx_on[1] -> width_lvl == 4'd0) &&
     (!fx_on[2] -> center_lvl == 4'd0) && (!fx_on[3] -> focus_lvl == 4'd0) &&
     (!fx_on[4] -> detail_lvl == 4'd0))); // R4

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bass_sel == 3'd2 && bypass && out_mute && fx_on == 5'h1F)); // R1
endmodule

bind acrb_regbank acrb_regbank_chk #(.PU_CYCLES(PU_CYCLES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bass_sel   (bass_sel),
  .atten_l    (atten_l),
  .atten_r    (atten_r),
  .out_mute   (out_mute),
  .bypass     (bypass),
  .fx_on      (fx_on),
  .punch_lvl  (punch_lvl),
  .width_lvl  (width_lvl),
  .center_lvl (center_lvl),
  .focus_lvl  (focus_lvl),
  .detail_lvl (detail_lvl)
);

// File: tb/acrb_regbank_test.sv
module acrb_regbank_test;
  localparam int PU  = 64;
  localparam int TMO = 6;
  localparam int VW  = 51;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slv_we = 1'b0, ldr_we = 1'b0, zero_cross = 1'b0;
  logic [2:0] slv_addr = '0, ldr_addr = '0;
  logic [7:0] slv_data = '0, ldr_data = '0;
  logic [2:0] bass_sel;
  logic [4:0] in_atten;
  logic [5:0] atten_l, atten_r;
  logic       out_mute, bypass, zc_en, comp_en, spatial_on, hp_mode;
  logic [4:0] fx_on;
  logic [3:0] punch_lvl, width_lvl, center_lvl, focus_lvl, detail_lvl;

  always #4 clk = ~clk;

  acrb_regbank #(.PU_CYCLES(PU), .ZC_TMO_W(TMO)) uut (
    .clk(clk), .rst(rst),
    .slv_we(slv_we), .slv_addr(slv_addr), .slv_data(slv_data),
    .ldr_we(ldr_we), .ldr_addr(ldr_addr), .ldr_data(ldr_data),
    .zero_cross(zero_cross),
    .bass_sel(bass_sel), .in_atten(in_atten), .atten_l(atten_l), .atten_r(atten_r),
    .out_mute(out_mute), .bypass(bypass), .zc_en(zc_en), .comp_en(comp_en),
    .spatial_on(spatial_on), .hp_mode(hp_mode), .fx_on(fx_on),
    .punch_lvl(punch_lvl), .width_lvl(width_lvl), .center_lvl(center_lvl),
    .focus_lvl(focus_lvl), .detail_lvl(detail_lvl)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] mreg [8];

  logic [VW-1:0] act;
  assign act = {bass_sel, in_atten, atten_l, atten_r, out_mute, bypass, zc_en,
                comp_en, spatial_on, hp_mode, fx_on,
                punch_lvl, width_lvl, center_lvl, focus_lvl, detail_lvl};

  function automatic logic [3:0] lv(input logic [7:0] r, input int eb);
    return r[eb] ? r[3:0] : 4'd0;
  endfunction

  function automatic logic [VW-1:0] model(input logic pu);
    logic m;
    m = pu | mreg[1][6] | (&mreg[1][5:0]) | (&mreg[2][5:0]);
    return {mreg[0][7:5], mreg[0][4:0], mreg[1][5:0], mreg[2][5:0], m, mreg[2][6],
            mreg[1][7], mreg[3][4], mreg[4][5], mreg[5][5],
            {mreg[7][4], mreg[6][4], mreg[5][4], mreg[4][4], mreg[3][5]},
            lv(mreg[3], 5), lv(mreg[4], 4), lv(mreg[5], 4), lv(mreg[6], 4), lv(mreg[7], 4)};
  endfunction

  task automatic check(input string req, input logic [63:0] a, input logic [63:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, a, e);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic swrite(input logic [2:0] a, input logic [7:0] d);
    slv_we = 1'b1; slv_addr = a; slv_data = d;
    @(negedge clk);
    slv_we = 1'b0;
    mreg[a] = d;
  endtask

  // {index, data}; requirement per row in the comment
  localparam logic [10:0] VEC [14] = '{
    {3'd0, 8'hE5},  // R2 bass code 7, input 5 dB
    {3'd1, 8'h0A},  // R3 left 10
    {3'd2, 8'h03},  // R3 bypass off, right 3
    {3'd3, 8'h0C},  // R4 R11 bass off with stored 12, compressor off
    {3'd3, 8'h2C},  // R4 bass back on, 12 returns
    {3'd4, 8'h17},  // R11 spatial off, width 7
    {3'd5, 8'h29},  // R4 R11 headphone on, center off
    {3'd6, 8'h05},  // R4 focus off
    {3'd7, 8'h1F},  // R4 detail 15
    {3'd1, 8'h3F},  // R6 left code 63
    {3'd1, 8'h40},  // R6 mute bit
    {3'd2, 8'h3F},  // R6 right code 63
    {3'd2, 8'h00},  // R6 right cleared
    {3'd1, 8'h00}   // R3 left cleared
  };

  initial begin
    #(8ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mreg[i] = 8'h00;
    mreg[0] = 8'h40; mreg[2] = 8'h40; mreg[3] = 8'h30; mreg[4] = 8'h30;
    mreg[5] = 8'h10; mreg[6] = 8'h10; mreg[7] = 8'h10;
    wait_cyc(5);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset outputs", 64'(act), 64'(model(1'b1)));
    check("R7 mute in power-up", 64'(out_mute), 64'd1);
    wait_cyc(PU + 4);
    check("R7 mute released", 64'(out_mute), 64'd0);
    check("R1 defaults after window", 64'(act), 64'(model(1'b0)));

    for (int v = 0; v < 14; v++) begin
      swrite(VEC[v][10:8], VEC[v][7:0]);
      wait_cyc(4);
      check($sformatf("R2-table row %0d", v), 64'(act), 64'(model(1'b0)));
    end

    // R10: direct attenuation path, two clocks
    swrite(3'd2, 8'h05);
    @(negedge clk);
    check("R10 right code after two clocks", 64'(atten_r), 64'd5);

    // R5: same index collision, loader wins
    ldr_we = 1'b1; ldr_addr = 3'd6; ldr_data = 8'h1A;
    slv_we = 1'b1; slv_addr = 3'd6; slv_data = 8'h13;
    @(negedge clk);
    ldr_addr = 3'd7; ldr_data = 8'h12;
    slv_addr = 3'd0; slv_data = 8'h27;
    @(negedge clk);
    ldr_we = 1'b0; slv_we = 1'b0;
    mreg[6] = 8'h1A; mreg[7] = 8'h12; mreg[0] = 8'h27;
    wait_cyc(3);
    check("R5 loader priority focus", 64'(focus_lvl), 64'd10);
    check("R5 both writes land", 64'(act), 64'(model(1'b0)));

    // R8: alignment holds the code until a pulse
    swrite(3'd1, 8'h94);
    wait_cyc(20);
    check("R3 zc_en bit", 64'(zc_en), 64'd1);
    check("R8 left held before pulse", 64'(atten_l), 64'd0);
    zero_cross = 1'b1;
    @(negedge clk);
    zero_cross = 1'b0;
    check("R8 left applied at pulse", 64'(atten_l), 64'd20);

    // R9: timeout releases the code
    swrite(3'd1, 8'h9E);
    wait_cyc(30);
    check("R9 left held before timeout", 64'(atten_l), 64'd20);
    wait_cyc(45);
    check("R9 left applied after timeout", 64'(atten_l), 64'd30);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule